// File: doc/BRIEF.md
# SPI Slave Port with Selectable Select Handling

A byte-wide serial slave that exchanges one data word with an external master per eight clock pulses. The master drives the serial clock, the active-low select and the serial input. The port returns its own transmit word on the serial output, most significant bit first. A small register window lets the host configure the port, load the next transmit word, collect the received word and clear the event flags. The serial clock, select and input pins are brought into the system clock domain through two-stage synchronizers before any edge is detected.

The control byte picks one of two slave behaviours. In the select-governed mode, a high select level holds the shift machinery in reset and leaves the data-out pin undriven. If select rises partway through a word, the partial word is thrown away. In the select-free mode, the select pin has no effect: the data-out pin is driven whenever the port is on, and words are framed only by counting clock edges. The clock idle level and the capture phase can be set, which gives all four of the usual clock arrangements.

Each finished word sets a completion flag, and that flag can raise the interrupt. If the receive buffer is empty, the word is moved into it and the buffer is marked full. If the buffer is already full, the new word is dropped and an overflow flag is set instead.

Top module: `spi_slave_port`

## Requirements
- R1: Reset clears the control, status and buffer state. The control byte at address 0 reads back as written. Its layout is: bits 3:0 mode, bit 4 clock idle level (1 = idle high), bit 5 port enable, bit 6 capture phase, bit 7 interrupt enable.
- R2: In mode 4'b0100 with the port enabled, `sdo_oe` is low while `ss_n` is high and high while `ss_n` is low.
- R3: In mode 4'b0101 with the port enabled, `sdo_oe` is high and words are exchanged whatever the level of `ss_n`.
- R4: When the enable bit is 0, or the mode is anything other than 4'b0100 or 4'b0101, `sdo_oe` is low and no word completes.
- R5: Words move most significant bit first. The received word equals the master's word, and the bits on `sdo` equal the word last written to address 1. A leading edge is the transition away from the idle level. With phase 0 the input is captured on the leading edge and the output changes on the trailing edge; with phase 1 the edges are swapped. All four idle-level and phase settings work.
- R6: In mode 4'b0100, a rise of `ss_n` partway through a word discards the partial word and sets no flag. The next word is received aligned.
- R7: Each completed word sets status bit 0. `irq` equals status bit 0 AND control bit 7. Writing a 1 to status bit 0 at address 2 clears it.
- R8: A completed word with the buffer empty is stored for reading at address 1 and sets status bit 1. A read strobe at address 1 clears status bit 1.
- R9: A completed word while status bit 1 is set leaves the buffer unchanged and sets status bit 2. Writing a 1 to status bit 2 clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears buffer-full when reading address 1) |
| reg_addr | input | 2 | Register address: 0 control, 1 data, 2 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the current address |
| sck | input | 1 | Serial clock from the master |
| ss_n | input | 1 | Active-low select from the master |
| sdi | input | 1 | Serial data from the master |
| sdo | output | 1 | Serial data to the master |
| sdo_oe | output | 1 | Drive enable for the serial data-out pin |
| irq | output | 1 | Word-complete interrupt, gated by the interrupt enable |

## Verification
The exchange is tried under every combination of idle level and phase, with random words in both directions. This separates a wrong capture edge or a wrong bit order from a correct one. Directed runs cover three more cases. A select pulse that rises mid-word tells apart a design that resets the framing from one that keeps counting. Two back-to-back words in the select-free mode, with no read in between, tell apart a design that overwrites the buffer from one that flags overflow. Disabled and undefined mode values are run with full clock bursts to show that neither the output driver nor the flags respond.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

    localparam int DATA_W = 8;

    localparam logic [3:0] MODE_SEL_GOVERNED = 4'b0100;
    localparam logic [3:0] MODE_SEL_FREE     = 4'b0101;

    typedef struct packed {
        logic       irq_en;
        logic       late_phase;
        logic       enable;
        logic       idle_high;
        logic [3:0] mode;
    } ctrl_t;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_DATA = 2'd1,
        ADDR_STAT = 2'd2
    } addr_e;

    function automatic logic port_active(ctrl_t c);
        return c.enable && (c.mode == MODE_SEL_GOVERNED || c.mode == MODE_SEL_FREE);
    endfunction

    function automatic logic select_governed(ctrl_t c);
        return c.mode == MODE_SEL_GOVERNED;
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int              W       = 3,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[g] <= RST_VAL;
            end else if (g == 0) begin
                stg[g] <= d;
            end else begin
                stg[g] <= stg[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_slave_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  ctrl_t        ctrl,
    input  logic         sck_s,
    input  logic         ss_s,
    input  logic         sdi_s,
    input  logic [W-1:0] tx_load,
    output logic         sdo,
    output logic         sdo_oe,
    output logic         byte_done,
    output logic [W-1:0] rx_byte
);
    localparam int            CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W-1);

    logic          sck_q;
    logic [CW-1:0] cnt;
    logic [W-1:0]  rx_sh;
    logic [W-1:0]  tx_sh;
    logic          active, hold, lead, trail, samp, shft;

    always_comb begin
        active = port_active(ctrl);
        hold   = !active || (select_governed(ctrl) && ss_s);
        lead   = (sck_q == ctrl.idle_high) && (sck_s != ctrl.idle_high);
        trail  = (sck_q != ctrl.idle_high) && (sck_s == ctrl.idle_high);
        samp   = ctrl.late_phase ? trail : lead;
        shft   = ctrl.late_phase ? lead  : trail;
    end

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            rx_sh <= '0;
            tx_sh <= '0;
        end else if (hold) begin
            cnt   <= '0;
            rx_sh <= '0;
            tx_sh <= tx_load;
        end else begin
            if (samp) begin
                rx_sh <= {rx_sh[W-2:0], sdi_s};
                cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
            end
            if (shft && cnt != '0) begin
                tx_sh <= {tx_sh[W-2:0], 1'b0};
            end else if (cnt == '0) begin
                tx_sh <= tx_load;
            end
        end
    end

    assign byte_done = !hold && samp && (cnt == LAST);
    assign rx_byte   = {rx_sh[W-2:0], sdi_s};
    assign sdo       = tx_sh[W-1];
    assign sdo_oe    = active && (!select_governed(ctrl) || !ss_s);

    // R6: a high select in the governed mode leaves the framing at bit zero
    assert_sel_clears_count_R6: assert property (@(posedge clk) disable iff (rst)
        (select_governed(ctrl) && ss_s) |=> (cnt == '0));
endmodule

// File: rtl/spi_regs.sv
module spi_regs
    import spi_slave_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reg_wr,
    input  logic         reg_rd,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    input  logic         byte_done,
    input  logic [W-1:0] rx_byte,
    output ctrl_t        ctrl,
    output logic [W-1:0] tx_hold,
    output logic [W-1:0] reg_rdata,
    output logic         irq
);
    logic [W-1:0] rx_buf;
    logic         done_flag, rx_full, overflow;
    addr_e        addr;

    assign addr = addr_e'(reg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            tx_hold   <= '0;
            rx_buf    <= '0;
            done_flag <= 1'b0;
            rx_full   <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            if (reg_wr && addr == ADDR_CTRL) ctrl    <= ctrl_t'(reg_wdata[7:0]);
            if (reg_wr && addr == ADDR_DATA) tx_hold <= reg_wdata;

            if (byte_done)                                   done_flag <= 1'b1;
            else if (reg_wr && addr == ADDR_STAT && reg_wdata[0]) done_flag <= 1'b0;

            if (byte_done && !rx_full) begin
                rx_buf  <= rx_byte;
                rx_full <= 1'b1;
            end else if (reg_rd && addr == ADDR_DATA) begin
                rx_full <= 1'b0;
            end

            if (byte_done && rx_full)                        overflow <= 1'b1;
            else if (reg_wr && addr == ADDR_STAT && reg_wdata[2]) overflow <= 1'b0;
        end
    end

    always_comb begin
        case (addr)
            ADDR_CTRL: reg_rdata = W'(ctrl);
            ADDR_DATA: reg_rdata = rx_buf;
            ADDR_STAT: reg_rdata = W'({overflow, rx_full, done_flag});
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = done_flag && ctrl.irq_en;

    // R7: the completion flag only rises after the shifter reports a word
    assert_done_from_word_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done_flag) |-> $past(byte_done));
    // R8: the buffer is only rewritten while it was empty
    assert_buf_kept_when_full_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_buf) |-> !$past(rx_full));
    // R9: overflow only arises on top of a full buffer
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(rx_full));
endmodule

// File: rtl/spi_slave_port.sv
module spi_slave_port
    import spi_slave_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         reg_wr,
    input  logic         reg_rd,
    input  logic [1:0]   reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic         sck,
    input  logic         ss_n,
    input  logic         sdi,
    output logic         sdo,
    output logic         sdo_oe,
    output logic         irq
);
    ctrl_t        ctrl;
    logic [W-1:0] tx_hold, rx_byte;
    logic         byte_done;
    logic [2:0]   pins_s;

    spi_sync #(.W(3), .STAGES(STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ss_n, sck, sdi}),
        .q   (pins_s)
    );

    spi_shift_core #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .sck_s     (pins_s[1]),
        .ss_s      (pins_s[2]),
        .sdi_s     (pins_s[0]),
        .tx_load   (tx_hold),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    spi_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .ctrl      (ctrl),
        .tx_hold   (tx_hold),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    // R4: an inactive port never drives the data-out pin nor completes a word
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !port_active(ctrl) |-> (!sdo_oe && !byte_done));
    // R3: select-free mode drives the pin whenever enabled
    assert_free_drives_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && ctrl.mode == MODE_SEL_FREE) |-> sdo_oe);
endmodule

// File: tb/spi_slave_port_bench.sv
module spi_slave_port_bench;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sck = 1'b0, ss_n = 1'b1, sdi = 1'b0;
    logic       sdo, sdo_oe, irq;

    int checks = 0;
    int errors = 0;
    bit done_run = 0;

    always #10 clk = ~clk;

    spi_slave_port u_spi_slave_port (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck(sck), .ss_n(ss_n), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .irq(irq)
    );

    function automatic logic [7:0] ctrl_byte(logic ie, logic ph, logic en, logic cp, logic [3:0] md);
        return {ie, ph, en, cp, md};
    endfunction

    function automatic logic [7:0] stat_byte(logic ov, logic full, logic dn);
        return {5'b0, ov, full, dn};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input bit strobe, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_rd = strobe;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic configure(input logic ie, input logic ph, input logic cp, input logic [3:0] md);
        wr(2'd0, ctrl_byte(ie, ph, 1'b0, cp, md));
        sck = cp;
        tick(6);
        wr(2'd0, ctrl_byte(ie, ph, 1'b1, cp, md));
        tick(2);
    endtask

    task automatic xfer(input logic [7:0] mbyte, input logic cp, input logic ph,
                        input bit use_ss, input int nbits,
                        output logic [7:0] got, output bit oe_ok);
        got = '0;
        oe_ok = 1;
        if (use_ss) ss_n = 1'b0;
        tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            if (!ph) begin
                sdi = mbyte[7-i];
                tick(HALF);
                sck = ~cp;
                got = {got[6:0], sdo};
                oe_ok &= sdo_oe;
                tick(HALF);
                sck = cp;
            end else begin
                sck = ~cp;
                sdi = mbyte[7-i];
                tick(HALF);
                sck = cp;
                got = {got[6:0], sdo};
                oe_ok &= sdo_oe;
                tick(HALF);
            end
        end
        tick(HALF);
        if (use_ss) ss_n = 1'b1;
        tick(HALF);
    endtask

    task automatic clear_all();
        logic [7:0] d;
        rd(2'd1, 1'b1, d);
        wr(2'd2, 8'h05);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_run) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, got;
        bit oe_ok;
        void'($urandom(32'h5EED1234));
        tick(4);
        rst = 1'b0;
        tick(2);

        // R1 reset state
        rd(2'd0, 0, d); check(d == 8'h00, "R1 reset ctrl", d, 0);
        rd(2'd2, 0, d); check(d == stat_byte(0,0,0), "R1 reset status", d, 0);
        check(sdo_oe == 1'b0, "R1 reset oe", sdo_oe, 0);
        wr(2'd0, 8'hE4);
        rd(2'd0, 0, d); check(d == 8'hE4, "R1 ctrl readback", d, 8'hE4);
        wr(2'd0, 8'h00);

        // R4 disabled, and enabled with an undefined mode
        wr(2'd0, ctrl_byte(0, 0, 0, 0, 4'b0100));
        ss_n = 1'b0; tick(6);
        check(sdo_oe == 1'b0, "R4 disabled oe", sdo_oe, 0);
        ss_n = 1'b1;
        configure(0, 0, 0, 4'b0000);
        xfer(8'h5A, 0, 0, 1, 8, got, oe_ok);
        check(!oe_ok, "R4 bad mode oe", oe_ok, 0);
        rd(2'd2, 0, d); check(d == stat_byte(0,0,0), "R4 bad mode no word", d, 0);

        // R2 + R5 + R8 select-governed basic exchange
        configure(0, 0, 0, 4'b0100);
        tick(6);
        check(sdo_oe == 1'b0, "R2 oe off while ss high", sdo_oe, 0);
        wr(2'd1, 8'hA5);
        ss_n = 1'b0; tick(6);
        check(sdo_oe == 1'b1, "R2 oe on while ss low", sdo_oe, 1);
        ss_n = 1'b1;
        xfer(8'h3C, 0, 0, 1, 8, got, oe_ok);
        check(got == 8'hA5, "R5 sdo word", got, 8'hA5);
        check(oe_ok, "R2 oe during word", oe_ok, 1);
        rd(2'd2, 0, d); check(d == stat_byte(0,1,1), "R8 full after word", d, stat_byte(0,1,1));
        check(irq == 1'b0, "R7 irq masked", irq, 0);
        rd(2'd1, 1, d); check(d == 8'h3C, "R8 rx word", d, 8'h3C);
        rd(2'd2, 0, d); check(d == stat_byte(0,0,1), "R8 read clears full", d, stat_byte(0,0,1));
        wr(2'd2, 8'h01);
        rd(2'd2, 0, d); check(d == stat_byte(0,0,0), "R7 done cleared", d, 0);

        // R7 interrupt gating
        configure(1, 1, 1, 4'b0100);
        xfer(8'hC3, 1, 1, 1, 8, got, oe_ok);
        check(irq == 1'b1, "R7 irq raised", irq, 1);
        wr(2'd2, 8'h01);
        tick(1);
        check(irq == 1'b0, "R7 irq cleared", irq, 0);
        clear_all();

        // R6 aborted word then aligned word
        configure(0, 0, 0, 4'b0100);
        wr(2'd1, 8'h0F);
        xfer(8'hFF, 0, 0, 1, 5, got, oe_ok);
        rd(2'd2, 0, d); check(d == stat_byte(0,0,0), "R6 partial discarded", d, 0);
        xfer(8'h96, 0, 0, 1, 8, got, oe_ok);
        check(got == 8'h0F, "R6 aligned sdo", got, 8'h0F);
        rd(2'd1, 1, d); check(d == 8'h96, "R6 aligned rx", d, 8'h96);
        clear_all();

        // R3 + R9 select-free, back-to-back words without reading
        configure(0, 0, 1, 4'b0101);
        wr(2'd1, 8'h81);
        tick(4);
        check(sdo_oe == 1'b1, "R3 oe with ss high", sdo_oe, 1);
        xfer(8'h11, 1, 0, 0, 8, got, oe_ok);
        check(got == 8'h81, "R3 sdo word", got, 8'h81);
        xfer(8'h22, 1, 0, 0, 8, got, oe_ok);
        check(got == 8'h81, "R3 second sdo word", got, 8'h81);
        rd(2'd2, 0, d); check(d == stat_byte(1,1,1), "R9 overflow set", d, stat_byte(1,1,1));
        rd(2'd1, 1, d); check(d == 8'h11, "R9 buffer kept", d, 8'h11);
        wr(2'd2, 8'h04);
        rd(2'd2, 0, d); check(d == stat_byte(0,0,1), "R9 overflow cleared", d, stat_byte(0,0,1));
        clear_all();

        // R5 random exchanges across all clock settings
        for (int it = 0; it < 24; it++) begin
            logic cp, ph, freem;
            logic [7:0] txb, mb;
            cp = 1'($urandom); ph = 1'($urandom); freem = 1'($urandom);
            txb = 8'($urandom); mb = 8'($urandom);
            configure(0, ph, cp, freem ? 4'b0101 : 4'b0100);
            wr(2'd1, txb);
            xfer(mb, cp, ph, !freem, 8, got, oe_ok);
            check(got == txb, "R5 random sdo", got, txb);
            check(oe_ok, "R5 random oe", oe_ok, 1);
            rd(2'd1, 1, d); check(d == mb, "R5 random rx", d, mb);
            clear_all();
        end

        done_run = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule